// File: doc/BRIEF.md
# Configuration address and data port translator

This block sits on a host I/O port bus and turns software accesses to a pair of 32-bit I/O registers into configuration transactions on a parallel local bus. Software first writes a full 32-bit word to the address port. That word holds an enable flag, a target bus, a device, a function, a register index and a two-bit cycle type. Software then reads or writes the data port. When the latched word allows it, the data access becomes exactly one configuration transaction on the bus side, which uses a request/acknowledge handshake.

For a local (type 0) target, the address phase replaces the device number with a one-hot select line on the upper address bits. For a downstream (type 1) target, the bus number and all the other fields are passed through. The host access is held until the bus side answers. If no transaction may be issued, the data port completes at once, a write is dropped and a read returns all ones.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset, cfg_req and io_ack are 0, and a full read of the address port returns 0.
- R2: A write to the address port (io_addr 0x0CF8) with io_be = 4'hF latches the word. A later full read returns it with bits 30..24 forced to zero. The fields are: bit 31 enable, bits 23..16 bus, bits 15..11 device, bits 10..8 function, bits 7..2 register index, bits 1..0 type.
- R3: An address-port access with io_be other than 4'hF leaves the latched word unchanged, and a read of that kind returns 0.
- R4: With enable 1, type 00 and device d ≤ 20, a data-port access (io_addr 0x0CFC) issues one transaction. Its address has only bit 11+d set among bits 31..11, the function in bits 10..8, the register index in bits 7..2, and 00 in bits 1..0.
- R5: With enable 1 and type 01, a data-port access issues one transaction whose address is {8'h00, bus, device, function, register index, 2'b01}.
- R6: With enable 0, a data-port access issues no transaction, a read returns 32'hFFFFFFFF, and the access is still acknowledged.
- R7: With type 10 or 11, a data-port access issues no transaction and a read returns 32'hFFFFFFFF.
- R8: With type 00 and device above 20, a data-port access issues no transaction and a read returns 32'hFFFFFFFF.
- R9: A transaction carries io_be unchanged on cfg_be, the access direction on cfg_wr, and io_wdata on cfg_wdata.
- R10: cfg_req stays high, with cfg_addr, cfg_be and cfg_wdata stable, until cfg_ack is sampled. io_ack rises in the cycle after that sample and returns the cfg_rdata value sampled with cfg_ack.
- R11: io_ack is high for exactly one cycle per access, and the host drops io_req in that cycle. An access to any other io_addr gets no io_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host access request, held until io_ack |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | Word-aligned I/O address |
| io_be | input | 4 | Byte lanes of the access |
| io_wdata | input | 32 | Host write data |
| io_ack | output | 1 | One-cycle completion strobe |
| io_rdata | output | 32 | Read data, valid with io_ack |
| cfg_req | output | 1 | Configuration transaction request |
| cfg_wr | output | 1 | Transaction direction |
| cfg_addr | output | 32 | Address-phase value |
| cfg_be | output | 4 | Byte enables of the transaction |
| cfg_wdata | output | 32 | Transaction write data |
| cfg_ack | input | 1 | Bus-side completion |
| cfg_rdata | input | 32 | Bus-side read data, valid with cfg_ack |

## Verification
An address-port access, or a data-port access that issues no transaction, raises io_ack one cycle after the edge that first sees io_req, and io_rdata is valid in that same cycle. An issued transaction raises cfg_req one cycle after that edge, and io_ack follows exactly one cycle after the edge that samples cfg_ack. The bench drives inputs and samples outputs on falling edges and counts cycles on rising edges. It records the cycle in which its responder raises cfg_ack and requires io_ack at the next one. The responder's latency is varied across the sweep. The responder also counts transaction starts, so the cases that must issue no transaction are checked by comparing that count before and after each access.

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 'h0CFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic             io_ack,
  output logic [31:0]      io_rdata,
  output logic             cfg_req,
  output logic             cfg_wr,
  output logic [31:0]      cfg_addr,
  output logic [3:0]       cfg_be,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_ack,
  input  logic [31:0]      cfg_rdata
);
  localparam int SEL_LO  = 11;
  localparam int SEL_W   = 32 - SEL_LO;
  localparam int MAX_DEV = SEL_W - 1;

  typedef enum logic [1:0] {IDLE, BUS, ACK} state_t;
  state_t state;

  logic       en_q;
  logic [7:0] bus_q;
  logic [4:0] dev_q;
  logic [2:0] fn_q;
  logic [5:0] idx_q;
  logic [1:0] typ_q;

  wire hit_a   = io_addr == ADDR_PORT;
  wire hit_d   = io_addr == DATA_PORT;
  wire full    = io_be == 4'hF;
  wire dev_ok  = 32'(dev_q) <= MAX_DEV;
  wire go      = en_q && ((typ_q == 2'b00 && dev_ok) || typ_q == 2'b01);

  wire [31:0]       addr_rd = {en_q, 7'b0, bus_q, dev_q, fn_q, idx_q, typ_q};
  wire [SEL_W-1:0]  sel     = dev_ok ? (SEL_W'(1) << dev_q) : '0;
  wire [31:0]       t0_addr = {sel, fn_q, idx_q, 2'b00};
  wire [31:0]       t1_addr = {8'h00, bus_q, dev_q, fn_q, idx_q, 2'b01};

  assign io_ack  = state == ACK;
  assign cfg_req = state == BUS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      en_q      <= 1'b0;
      bus_q     <= '0;
      dev_q     <= '0;
      fn_q      <= '0;
      idx_q     <= '0;
      typ_q     <= '0;
      io_rdata  <= '0;
      cfg_wr    <= 1'b0;
      cfg_addr  <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
    end else begin
      case (state)
        IDLE: if (io_req) begin
          if (hit_a) begin
            if (io_wr && full) begin
              en_q  <= io_wdata[31];
              bus_q <= io_wdata[23:16];
              dev_q <= io_wdata[15:11];
              fn_q  <= io_wdata[10:8];
              idx_q <= io_wdata[7:2];
              typ_q <= io_wdata[1:0];
            end
            io_rdata <= full ? addr_rd : '0;
            state    <= ACK;
          end else if (hit_d) begin
            if (go) begin
              cfg_wr    <= io_wr;
              cfg_addr  <= typ_q[0] ? t1_addr : t0_addr;
              cfg_be    <= io_be;
              cfg_wdata <= io_wdata;
              state     <= BUS;
            end else begin
              io_rdata <= '1;
              state    <= ACK;
            end
          end
        end
        BUS: if (cfg_ack) begin
          io_rdata <= cfg_rdata;
          state    <= ACK;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_be) && $stable(cfg_wdata));

  assert_ack_follows_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack |=> io_ack && !cfg_req && io_rdata == $past(cfg_rdata));

  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    io_ack |=> !io_ack);

  assert_onehot_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_addr[1:0] == 2'b00 |-> $countones(cfg_addr[31:SEL_LO]) == 1);

  assert_type1_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_addr[1:0] == 2'b01 |-> cfg_addr[31:24] == 8'h00);

  assert_no_cycle_when_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_ack |-> !cfg_req);
endmodule

// File: tb/cfg_port_bridge_test.sv
module cfg_port_bridge_test;
  logic clk = 0, rst_n = 0;
  logic io_req = 0, io_wr = 0;
  logic [15:0] io_addr = 0;
  logic [3:0] io_be = 0;
  logic [31:0] io_wdata = 0;
  logic io_ack, cfg_req, cfg_wr;
  logic [31:0] io_rdata, cfg_addr, cfg_wdata;
  logic [3:0] cfg_be;
  logic cfg_ack = 0;
  logic [31:0] cfg_rdata = 0;

  int checks = 0, errors = 0, cyc = 0;
  int starts = 0, lat = 0, wcnt = 0, ack_cyc = 0, host_cyc = 0;
  logic [31:0] first_addr, cap_addr, cap_wdata;
  logic [3:0] cap_be;
  logic cap_wr, unstable = 0, prev_req = 0;

  cfg_port_bridge uut (.clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
    .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata), .io_ack(io_ack),
    .io_rdata(io_rdata), .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cfg_req) begin
      if (!prev_req) begin starts++; first_addr = cfg_addr; wcnt = 0; end
      else if (cfg_addr != first_addr) unstable = 1;
      if (wcnt >= lat && !cfg_ack) begin
        cfg_ack = 1; ack_cyc = cyc;
        cfg_rdata = cfg_addr ^ 32'h5A5A_0F0F;
        cap_addr = cfg_addr; cap_be = cfg_be; cap_wdata = cfg_wdata; cap_wr = cfg_wr;
      end
      wcnt++;
    end else cfg_ack = 0;
    prev_req = cfg_req;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    io_req = 1; io_wr = wr; io_addr = a; io_be = be; io_wdata = wd;
    forever begin
      @(negedge clk);
      if (io_ack) begin rd = io_rdata; host_cyc = cyc; io_req = 0; break; end
    end
    @(negedge clk);
    check("R11 ack width", {31'b0, io_ack}, 0);
  endtask

  function automatic logic [31:0] t0_exp(int d, int f, int x);
    return (32'(1) << (11 + d)) | 32'(f << 8) | 32'(x << 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int s0;
    repeat (3) @(negedge clk);
    check("R1 cfg_req", {31'b0, cfg_req}, 0);
    check("R1 io_ack", {31'b0, io_ack}, 0);
    rst_n = 1;
    access(0, 16'h0CF8, 4'hF, 0, rd);
    check("R1 addr reset", rd, 0);

    access(1, 16'h0CF8, 4'hF, 32'hFFAB_C35D, rd);
    access(0, 16'h0CF8, 4'hF, 0, rd);
    check("R2 readback", rd, 32'h80AB_C35D);

    for (int b = 0; b < 15; b++) begin
      access(1, 16'h0CF8, 4'(b), 32'h1234_5678, rd);
      access(0, 16'h0CF8, 4'(b), 0, rd);
      check("R3 narrow read", rd, 0);
      access(0, 16'h0CF8, 4'hF, 0, rd);
      check("R3 unchanged", rd, 32'h80AB_C35D);
    end

    for (int d = 0; d < 32; d++) begin
      int f = d % 8, x = (d * 5) % 64;
      lat = d % 4;
      access(1, 16'h0CF8, 4'hF, {1'b1, 7'b0, 8'(d * 3), 5'(d), 3'(f), 6'(x), 2'b00}, rd);
      s0 = starts;
      access(0, 16'h0CFC, 4'hF, 0, rd);
      if (d <= 20) begin
        check("R4 one cycle", starts - s0, 1);
        check("R4 addr", cap_addr, t0_exp(d, f, x));
        check("R10 rdata", rd, t0_exp(d, f, x) ^ 32'h5A5A_0F0F);
        check("R10 ack timing", host_cyc, ack_cyc + 1);
        check("R9 read dir", {31'b0, cap_wr}, 0);
      end else begin
        check("R8 no cycle", starts - s0, 0);
        check("R8 all ones", rd, 32'hFFFF_FFFF);
      end
    end

    for (int k = 0; k < 16; k++) begin
      logic [7:0] bus = 8'(k * 17 + 3);
      logic [4:0] dv = 5'(31 - k);
      lat = k % 3;
      access(1, 16'h0CF8, 4'hF, {1'b1, 7'b0, bus, dv, 3'(k), 6'(k * 4), 2'b01}, rd);
      s0 = starts;
      access(1, 16'h0CFC, 4'(k), 32'hC0DE_0000 + k, rd);
      check("R5 one cycle", starts - s0, 1);
      check("R5 addr", cap_addr, {8'h00, bus, dv, 3'(k), 6'(k * 4), 2'b01});
      check("R9 be", {28'b0, cap_be}, k);
      check("R9 wdata", cap_wdata, 32'hC0DE_0000 + k);
      check("R9 write dir", {31'b0, cap_wr}, 1);
      check("R10 hold", {31'b0, unstable}, 0);
    end

    access(1, 16'h0CF8, 4'hF, {1'b0, 7'b0, 8'h01, 5'd2, 3'd1, 6'd3, 2'b00}, rd);
    s0 = starts;
    access(0, 16'h0CFC, 4'hF, 0, rd);
    check("R6 all ones", rd, 32'hFFFF_FFFF);
    access(1, 16'h0CFC, 4'hF, 32'h1111_2222, rd);
    check("R6 no cycle", starts - s0, 0);

    for (int t = 2; t < 4; t++) begin
      access(1, 16'h0CF8, 4'hF, {1'b1, 7'b0, 8'h05, 5'd1, 3'd0, 6'd1, 2'(t)}, rd);
      s0 = starts;
      access(0, 16'h0CFC, 4'hF, 0, rd);
      check("R7 all ones", rd, 32'hFFFF_FFFF);
      check("R7 no cycle", starts - s0, 0);
    end

    @(negedge clk);
    io_req = 1; io_wr = 0; io_addr = 16'h0CF4; io_be = 4'hF;
    s0 = 0;
    repeat (10) begin @(negedge clk); if (io_ack) s0++; end
    io_req = 0;
    check("R11 other addr", s0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule